// File: doc/BRIEF.md
# Machine Control and Fault Entry Unit

This unit holds the 64-bit machine control word of a small processor core, together with the register that keeps the address to resume at after a fault. It decides when a fault is taken, updates the control word, and tells the fetch stage where to go next. Fault sources are a synchronous fault request from the pipeline, a supervisor-call request, a gated external interrupt, and misuse of its own privileged ports.

The control word has two halves. The low half is the live state: interrupt-disable at bit 19, condition flag at bit 18, mode at bits 17:16, cause at bits 11:8 and comment at bits 7:0. Bits 31:20 and 15:12 always read zero. The high half is a one-level shadow. On fault entry the live half is copied into the shadow. A return request copies the shadow back and redirects fetch to the saved return address. Every request is sampled on a rising clock edge, and its effect shows on the outputs after that edge. At most one action is taken per cycle.

All pins are plain control and status wires, with no valid/ready handshake. The core holds a request for one cycle per event and does not need back-pressure, because the unit accepts one action in every cycle.

Top module: `mfu_core`

## Requirements
- R1: After reset the low word reads 0x00090F00 (interrupt-disable 1, condition 0, mode 01 Supervisor, cause 1111, comment 0x00), the high word and the return address read zero, and redirect is low.
- R2: Mode 00 is User and 01 is Supervisor. A Supervisor control write whose bit 17 is set (mode 10 or 11) does not change the mode. It raises a fault with cause 0100, and the saved return address is the current pc.
- R3: On fault entry the high word receives the previous low word. The new low word has interrupt-disable 1, mode 01, the new cause in bits 11:8, the condition flag and comment kept, and the zero fields at 0. Redirect is high for the next cycle with the handler address 0x00000000.
- R4: On a synchronous fault, the return address becomes pc when the "next" select is 0 and pc+4 when it is 1. The cause is taken from the request.
- R5: The external interrupt raises cause 1100 with return address pc+4, but only in a cycle where the boundary strobe is high and interrupt-disable is 0. Otherwise it has no effect.
- R6: Only one request is honoured per cycle, in this order: synchronous fault, supervisor call, return, control write, return-address write, external interrupt. An interrupt line that is still high is taken at a later boundary.
- R7: A return in Supervisor mode copies the high word into the low word, leaves the high word and the return address unchanged, and pulses redirect with the saved return address.
- R8: A return, control write or return-address write issued in User mode changes no register except through fault entry with cause 0101, and the saved return address is the current pc.
- R9: A supervisor call loads the comment field with the supplied byte, raises cause 1110, and saves pc+4.
- R10: In Supervisor mode a control write replaces the low word, forcing bits 31:20 and 15:12 to zero, and a return-address write replaces the return address.
- R11: The mode, condition and interrupt-disable outputs always equal bits 17:16, 18 and 19 of the low word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc | input | 32 | Address of the instruction now executing |
| fault_req | input | 1 | Synchronous fault request |
| fault_cause | input | 4 | Cause code for the synchronous fault |
| fault_next | input | 1 | 1: save pc+4, 0: save pc |
| irq | input | 1 | External interrupt level |
| boundary | input | 1 | Current instruction completes this cycle |
| svc_req | input | 1 | Supervisor-call request |
| svc_comment | input | 8 | Byte loaded into the comment field |
| ret_req | input | 1 | Return-from-fault request |
| cw_wr | input | 1 | Privileged control-word write |
| cw_wdata | input | 32 | Data for the low control word |
| ra_wr | input | 1 | Privileged return-address write |
| ra_wdata | input | 32 | New return address |
| ctl_word | output | 64 | Full control word (shadow in 63:32) |
| mode | output | 2 | Current mode |
| cond_t | output | 1 | Condition flag |
| int_dis | output | 1 | Interrupt-disable flag |
| ret_addr | output | 32 | Saved return address |
| redirect | output | 1 | Fetch redirect strobe |
| redirect_addr | output | 32 | Redirect target |

## Verification
Every cycle, the assertions check the following: fault entry always reaches Supervisor mode with interrupts disabled and the old low word in the shadow, the mode never reads a reserved value, the zero fields stay zero, a masked interrupt is ignored, and User-mode privileged requests become privilege faults. Only the bench scenarios can show the rest, because they need multi-cycle histories. These cover the full round trip from user code through a fault and back, priority between requests that arrive together, an interrupt that waits until a later boundary, and the exact return address that each source saves.

// File: rtl/mfu_pkg.sv
`timescale 1ns/1ps
package mfu_pkg;
  localparam int CTL_W = 64;

  typedef enum logic [3:0] {
    CAUSE_MIS_LD    = 4'h0,
    CAUSE_MIS_ST    = 4'h1,
    CAUSE_BAD_STATE = 4'h4,
    CAUSE_PRIV      = 4'h5,
    CAUSE_UNDEF     = 4'h8,
    CAUSE_EXT_IRQ   = 4'hC,
    CAUSE_USER_IRQ  = 4'hD,
    CAUSE_SVC       = 4'hE,
    CAUSE_RESET     = 4'hF
  } cause_e;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_ENTER,
    ACT_RETURN,
    ACT_CW_WRITE,
    ACT_RA_WRITE
  } act_e;

  localparam logic [1:0] MODE_USER  = 2'b00;
  localparam logic [1:0] MODE_SUPER = 2'b01;

  typedef struct packed {
    logic [11:0] zero_hi;
    logic        int_dis;
    logic        cond_t;
    logic [1:0]  mode;
    logic [3:0]  zero_lo;
    logic [3:0]  cause;
    logic [7:0]  comment;
  } ctl_low_t;
endpackage

// File: rtl/mfu_arbiter.sv
`timescale 1ns/1ps
module mfu_arbiter
  import mfu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fault_req,
  input  logic [3:0] fault_cause,
  input  logic       fault_next,
  input  logic       svc_req,
  input  logic       ret_req,
  input  logic       cw_wr,
  input  logic       cw_mode_rsvd,
  input  logic       ra_wr,
  input  logic       irq,
  input  logic       boundary,
  input  logic [1:0] mode,
  input  logic       int_dis,
  output act_e       act,
  output logic [3:0] cause,
  output logic       use_next,
  output logic       load_comment
);
  logic is_user;
  assign is_user = (mode == MODE_USER);

  always_comb begin
    act          = ACT_NONE;
    cause        = fault_cause;
    use_next     = fault_next;
    load_comment = 1'b0;
    if (fault_req) begin
      act = ACT_ENTER;
    end else if (svc_req) begin
      act          = ACT_ENTER;
      cause        = CAUSE_SVC;
      use_next     = 1'b1;
      load_comment = 1'b1;
    end else if (ret_req || cw_wr || ra_wr) begin
      if (is_user) begin
        act      = ACT_ENTER;
        cause    = CAUSE_PRIV;
        use_next = 1'b0;
      end else if (ret_req) begin
        act = ACT_RETURN;
      end else if (cw_wr && cw_mode_rsvd) begin
        act      = ACT_ENTER;
        cause    = CAUSE_BAD_STATE;
        use_next = 1'b0;
      end else if (cw_wr) begin
        act = ACT_CW_WRITE;
      end else begin
        act = ACT_RA_WRITE;
      end
    end else if (irq && boundary && !int_dis) begin
      act      = ACT_ENTER;
      cause    = CAUSE_EXT_IRQ;
      use_next = 1'b1;
    end
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (int_dis && !fault_req && !svc_req && !ret_req && !cw_wr && !ra_wr) |-> act == ACT_NONE); // R5
  AST_USER_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_USER && !fault_req && !svc_req && (ret_req || cw_wr || ra_wr))
      |-> (act == ACT_ENTER && cause == CAUSE_PRIV && !use_next)); // R8
  AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req |-> (act == ACT_ENTER && cause == fault_cause)); // R6
endmodule

// File: rtl/mfu_ctlreg.sv
`timescale 1ns/1ps
module mfu_ctlreg
  import mfu_pkg::*;
#(
  parameter int                ADDR_W       = 32,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  act_e              act,
  input  logic [3:0]        cause,
  input  logic              use_next,
  input  logic              load_comment,
  input  logic [7:0]        comment_in,
  input  logic [31:0]       cw_wdata,
  input  logic [ADDR_W-1:0] ra_wdata,
  input  logic [ADDR_W-1:0] pc,
  output logic [CTL_W-1:0]  ctl,
  output logic [ADDR_W-1:0] ra,
  output logic              redirect,
  output logic [ADDR_W-1:0] redirect_addr
);
  localparam logic [ADDR_W-1:0] INSN_STEP = ADDR_W'(4);

  ctl_low_t    lo_q, lo_entry, lo_write;
  logic [31:0] hi_q;

  always_comb begin
    lo_entry         = '0;
    lo_entry.int_dis = 1'b1;
    lo_entry.cond_t  = lo_q.cond_t;
    lo_entry.mode    = MODE_SUPER;
    lo_entry.cause   = cause;
    lo_entry.comment = load_comment ? comment_in : lo_q.comment;
    lo_write         = ctl_low_t'(cw_wdata);
    lo_write.zero_hi = '0;
    lo_write.zero_lo = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q          <= '0;
      lo_q          <= '{zero_hi: '0, int_dis: 1'b1, cond_t: 1'b0, mode: MODE_SUPER,
                         zero_lo: '0, cause: CAUSE_RESET, comment: '0};
      ra            <= '0;
      redirect      <= 1'b0;
      redirect_addr <= '0;
    end else begin
      redirect <= 1'b0;
      unique case (act)
        ACT_ENTER: begin
          hi_q          <= lo_q;
          lo_q          <= lo_entry;
          ra            <= use_next ? pc + INSN_STEP : pc;
          redirect      <= 1'b1;
          redirect_addr <= HANDLER_ADDR;
        end
        ACT_RETURN: begin
          lo_q          <= ctl_low_t'(hi_q);
          redirect      <= 1'b1;
          redirect_addr <= ra;
        end
        ACT_CW_WRITE: lo_q <= lo_write;
        ACT_RA_WRITE: ra   <= ra_wdata;
        default: ;
      endcase
    end
  end

  assign ctl = {hi_q, lo_q};

  AST_ENTRY_SUPER: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_ENTER |=> (ctl[17:16] == MODE_SUPER && ctl[19] && redirect
                          && redirect_addr == HANDLER_ADDR)); // R3
  AST_SHADOW_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_ENTER |=> ctl[63:32] == $past(ctl[31:0])); // R3
  AST_ZERO_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[31:20] == '0 && ctl[15:12] == '0)); // R3
  AST_NO_RESERVED_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[17]); // R2
  AST_RA_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_ENTER && use_next) |=> ra == $past(pc) + INSN_STEP); // R4
  AST_RETURN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_RETURN |=> (ctl[31:0] == $past(ctl[63:32]) && redirect
                           && redirect_addr == $past(ra))); // R7
endmodule

// File: rtl/mfu_core.sv
`timescale 1ns/1ps
module mfu_core
  import mfu_pkg::*;
#(
  parameter int                ADDR_W       = 32,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] pc,
  input  logic              fault_req,
  input  logic [3:0]        fault_cause,
  input  logic              fault_next,
  input  logic              irq,
  input  logic              boundary,
  input  logic              svc_req,
  input  logic [7:0]        svc_comment,
  input  logic              ret_req,
  input  logic              cw_wr,
  input  logic [31:0]       cw_wdata,
  input  logic              ra_wr,
  input  logic [ADDR_W-1:0] ra_wdata,
  output logic [CTL_W-1:0]  ctl_word,
  output logic [1:0]        mode,
  output logic              cond_t,
  output logic              int_dis,
  output logic [ADDR_W-1:0] ret_addr,
  output logic              redirect,
  output logic [ADDR_W-1:0] redirect_addr
);
  act_e       act;
  logic [3:0] sel_cause;
  logic       sel_next, sel_comment;

  assign mode    = ctl_word[17:16];
  assign cond_t  = ctl_word[18];
  assign int_dis = ctl_word[19];

  mfu_arbiter i_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .fault_req    (fault_req),
    .fault_cause  (fault_cause),
    .fault_next   (fault_next),
    .svc_req      (svc_req),
    .ret_req      (ret_req),
    .cw_wr        (cw_wr),
    .cw_mode_rsvd (cw_wdata[17]),
    .ra_wr        (ra_wr),
    .irq          (irq),
    .boundary     (boundary),
    .mode         (mode),
    .int_dis      (int_dis),
    .act          (act),
    .cause        (sel_cause),
    .use_next     (sel_next),
    .load_comment (sel_comment)
  );

  mfu_ctlreg #(.ADDR_W(ADDR_W), .HANDLER_ADDR(HANDLER_ADDR)) i_reg (
    .clk           (clk),
    .rst_n         (rst_n),
    .act           (act),
    .cause         (sel_cause),
    .use_next      (sel_next),
    .load_comment  (sel_comment),
    .comment_in    (svc_comment),
    .cw_wdata      (cw_wdata),
    .ra_wdata      (ra_wdata),
    .pc            (pc),
    .ctl           (ctl_word),
    .ra            (ret_addr),
    .redirect      (redirect),
    .redirect_addr (redirect_addr)
  );

  AST_STATUS_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ctl_word[17:16] && int_dis == ctl_word[19])); // R11
endmodule

// File: tb/test_mfu_core.sv
`timescale 1ns/1ps
module test_mfu_core;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] pc = '0;
  logic        fault_req = 0, fault_next = 0, irq = 0, boundary = 0;
  logic [3:0]  fault_cause = '0;
  logic        svc_req = 0, ret_req = 0, cw_wr = 0, ra_wr = 0;
  logic [7:0]  svc_comment = '0;
  logic [31:0] cw_wdata = '0, ra_wdata = '0;
  logic [63:0] ctl_word;
  logic [1:0]  mode;
  logic        cond_t, int_dis, redirect;
  logic [31:0] ret_addr, redirect_addr;

  int compared = 0, mismatched = 0;
  bit done = 0;

  logic [63:0] m_ctl;
  logic [31:0] m_ra, m_raddr;
  logic        m_redir;

  always #2 clk = ~clk;

  mfu_core i_mfu_core (
    .clk(clk), .rst_n(rst_n), .pc(pc), .fault_req(fault_req), .fault_cause(fault_cause),
    .fault_next(fault_next), .irq(irq), .boundary(boundary), .svc_req(svc_req),
    .svc_comment(svc_comment), .ret_req(ret_req), .cw_wr(cw_wr), .cw_wdata(cw_wdata),
    .ra_wr(ra_wr), .ra_wdata(ra_wdata), .ctl_word(ctl_word), .mode(mode), .cond_t(cond_t),
    .int_dis(int_dis), .ret_addr(ret_addr), .redirect(redirect), .redirect_addr(redirect_addr));

  task automatic cmp(string tag, string what, logic [63:0] got, logic [63:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic enter(logic [3:0] c, logic [31:0] addr, bit lc, logic [7:0] cb);
    logic [31:0] old;
    old     = m_ctl[31:0];
    m_ctl   = {old, 12'h000, 1'b1, old[18], 2'b01, 4'h0, c, lc ? cb : old[7:0]};
    m_ra    = addr;
    m_redir = 1'b1;
    m_raddr = 32'h0;
  endtask

  task automatic model_update();
    bit user;
    user    = (m_ctl[17:16] == 2'b00);
    m_redir = 1'b0;
    if (fault_req) enter(fault_cause, fault_next ? pc + 4 : pc, 0, 8'h00);
    else if (svc_req) enter(4'hE, pc + 4, 1, svc_comment);
    else if ((ret_req || cw_wr || ra_wr) && user) enter(4'h5, pc, 0, 8'h00);
    else if (ret_req) begin
      m_ctl[31:0] = m_ctl[63:32];
      m_redir = 1'b1;
      m_raddr = m_ra;
    end
    else if (cw_wr && cw_wdata[17]) enter(4'h4, pc, 0, 8'h00);
    else if (cw_wr) m_ctl[31:0] = cw_wdata & 32'h000F_0FFF;
    else if (ra_wr) m_ra = ra_wdata;
    else if (irq && boundary && !m_ctl[19]) enter(4'hC, pc + 4, 0, 8'h00);
  endtask

  task automatic compare_all(string tag);
    cmp(tag, "ctl_word", ctl_word, m_ctl);
    cmp(tag, "ret_addr", {32'h0, ret_addr}, {32'h0, m_ra});
    cmp(tag, "redirect", {63'h0, redirect}, {63'h0, m_redir});
    if (m_redir) cmp(tag, "redirect_addr", {32'h0, redirect_addr}, {32'h0, m_raddr});
    // R11: status pins decode the low word
    cmp({tag, "/R11"}, "status", {60'h0, int_dis, cond_t, mode},
        {60'h0, m_ctl[19], m_ctl[18], m_ctl[17:16]});
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare_all(tag);
    fault_req = 0; svc_req = 0; ret_req = 0; cw_wr = 0; ra_wr = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    m_ctl = 64'h0000_0000_0009_0F00; m_ra = '0; m_redir = 0; m_raddr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    cmp("R1", "ctl_word", ctl_word, 64'h0000_0000_0009_0F00);
    cmp("R1", "ret_addr", {32'h0, ret_addr}, 64'h0);
    cmp("R1", "redirect", {63'h0, redirect}, 64'h0);
    compare_all("R1");

    // R10 supervisor write, zero fields forced: drop to User, T=1, comment AB
    cw_wr = 1; cw_wdata = 32'hFFF4_F0AB; step("R10");
    cmp("R10", "low word", {32'h0, ctl_word[31:0]}, 64'h0000_0000_0004_00AB);

    // R5 interrupt off boundary ignored, then taken
    irq = 1; boundary = 0; pc = 32'h100; step("R5");
    boundary = 1; step("R5");
    cmp("R3", "ctl_word", ctl_word, 64'h0004_00AB_000D_0CAB);
    cmp("R5", "ret_addr", {32'h0, ret_addr}, 64'h104);
    cmp("R3", "redirect", {63'h0, redirect}, 64'h1);
    // R5 masked while interrupt-disable is set
    step("R5"); step("R5");
    irq = 0; boundary = 0;

    // R7 return to User
    ret_req = 1; step("R7");
    cmp("R7", "redirect_addr", {32'h0, redirect_addr}, 64'h104);

    // R8 privileged requests from User
    pc = 32'h180;
    ret_req = 1; step("R8"); cmp("R8", "ret_addr", {32'h0, ret_addr}, 64'h180);
    ret_req = 1; step("R7");
    cw_wr = 1; cw_wdata = 32'h0001_0000; step("R8");
    ret_req = 1; step("R7");
    ra_wr = 1; ra_wdata = 32'hDEAD_BEE0; step("R8");
    ret_req = 1; step("R7");

    // R9 supervisor call
    pc = 32'h200; svc_req = 1; svc_comment = 8'h5A; step("R9");
    cmp("R9", "cause/comment", {48'h0, ctl_word[15:0]}, 64'h0E5A);
    ret_req = 1; step("R7");

    // R6 sync fault wins over interrupt, interrupt taken later
    pc = 32'h300; irq = 1; boundary = 1;
    fault_req = 1; fault_cause = 4'h0; fault_next = 0; svc_req = 1; step("R6");
    cmp("R6", "cause", {60'h0, ctl_word[11:8]}, 64'h0);
    cmp("R4", "ret_addr", {32'h0, ret_addr}, 64'h300);
    ret_req = 1; step("R6");
    step("R6");
    cmp("R6", "cause", {60'h0, ctl_word[11:8]}, 64'hC);
    irq = 0; boundary = 0;

    // R4 next-address select on nested fault
    pc = 32'h400; fault_req = 1; fault_cause = 4'h8; fault_next = 1; step("R4");
    cmp("R4", "ret_addr", {32'h0, ret_addr}, 64'h404);

    // R2 reserved mode write
    pc = 32'h480; cw_wr = 1; cw_wdata = 32'h0002_0000; step("R2");
    cmp("R2", "cause", {60'h0, ctl_word[11:8]}, 64'h4);

    // R10 return-address write then return uses it
    ra_wr = 1; ra_wdata = 32'h1234_5678; step("R10");
    ret_req = 1; step("R10");
    cmp("R10", "redirect_addr", {32'h0, redirect_addr}, 64'h1234_5678);

    // R6 mixed traffic against the reference model
    for (int i = 0; i < 300; i++) begin
      pc          = $urandom & 32'hFFFF_FFFC;
      fault_req   = ($urandom % 9) == 0;
      fault_cause = 4'($urandom);
      fault_next  = 1'($urandom);
      svc_req     = ($urandom % 9) == 0;
      svc_comment = 8'($urandom);
      ret_req     = ($urandom % 4) == 0;
      cw_wr       = ($urandom % 6) == 0;
      cw_wdata    = $urandom;
      ra_wr       = ($urandom % 6) == 0;
      ra_wdata    = $urandom;
      irq         = 1'($urandom);
      boundary    = 1'($urandom);
      step("R6");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule